// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block produces the time quantum and per-bit timing for one CAN node. A 16-bit configuration word sets four values. The first is a prescaler that divides the system clock into time quanta. The second and third are the lengths of the two timing segments that follow the one-quantum sync segment. The fourth is the resynchronization jump width. The word can be changed only while the bus logic is halted.

Once running, the block waits idle for a recessive-to-dominant edge on the receive line. That first edge hard-synchronizes the bit: the quantum divider and the segment sequencer both restart at the sync segment. After that, the block steps through sync, segment 1 and segment 2 for each bit. It emits a one-cycle bit-start strobe at the start of each bit and a one-cycle sample strobe at the end of segment 1. The receive value is latched at that sample point. Falling edges that arrive later in the bit stretch segment 1 or shrink segment 2, by no more than the jump width and at most once per bit.

Top module: `can_bit_timer`

## Requirements
- R1: In reset, `cfg_rdata` reads 0x7FFF, `bit_start`, `sample_stb` and `tq_tick` are low, and `rx_sampled` is 1.
- R2: A write (`cfg_wr`=1) updates the configuration on the next clock only while `halt`=1. A write while `halt`=0 leaves `cfg_rdata` unchanged.
- R3: Bit 15 of the configuration is unused and always reads 0.
- R4: The prescaler value P sits in bits 5:0. While running, `tq_tick` is a one-cycle pulse once every P+1 clocks, starting P clocks after a hard sync.
- R5: The segment 1 value T1 sits in bits 11:8 and the segment 2 value T2 in bits 14:12. With no resync, a bit lasts (P+1)(T1+T2+3) clocks. `sample_stb` rises (P+1)(T1+2) clocks after that bit's `bit_start`.
- R6: While running and idle, a 1-to-0 transition on `rx` causes a hard sync. `bit_start` is high in the cycle after the cycle in which `rx` first reads 0.
- R7: The jump width value J sits in bits 7:6. A falling edge in segment 1, during its quantum q (counted from 0), lengthens segment 1 by min(q+1, J+1) quanta.
- R8: A falling edge in segment 2, during its quantum q, shortens segment 2 by min(T2+1-q, J+1) quanta. If that reaches the current quantum, the bit ends at the end of that quantum.
- R9: Only the first resynchronizing edge within a bit has any effect. Later edges in the same bit are ignored.
- R10: `rx_sampled` takes the value of `rx` in the cycle that ends segment 1 and changes at no other time.
- R11: While `halt`=1 there are no strobes or ticks and `rx` edges are ignored. After `halt` falls, the block stays idle until a falling edge arrives.
- R12: `bit_start` and `sample_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | 1 = bus logic stopped, configuration writable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Current configuration word |
| rx | input | 1 | Receive line (1 = recessive) |
| tq_tick | output | 1 | One-cycle pulse at the last clock of each quantum |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| bit_start | output | 1 | One-cycle pulse at the start of each bit |
| rx_sampled | output | 1 | Receive value captured at the sample point |

## Verification
The bench chooses edge positions that separate correct behaviour from likely mistakes. An edge in the third quantum of segment 1 would stretch a design with no jump-width limit by three quanta instead of two. An edge in the first quantum followed by one in the fourth catches a design that resynchronizes twice in one bit, because the sample point would move by two quanta rather than one. An edge in the second quantum of segment 2 must end the bit at once; a design that uses the wrong sign or the wrong remaining count would start the next bit late. Further tests toggle `rx` during halt and attempt writes while running; a design that leaks either would produce strobes or a changed configuration.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_IDLE = 2'd0,
    SEG_SYNC = 2'd1,
    SEG_TS1  = 2'd2,
    SEG_TS2  = 2'd3
  } seg_t;
endpackage

// File: rtl/can_bt_cfgreg.sv
module can_bt_cfgreg #(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata
);
  logic [CFG_W-2:0] cfg_q, cfg_d;
  logic             unused_top_bit;

  assign unused_top_bit = wdata[CFG_W-1];

  always_comb begin
    cfg_d = cfg_q;
    if (wr && halt) cfg_d = wdata[CFG_W-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= {(CFG_W-1){1'b1}};
    else        cfg_q <= cfg_d;
  end

  assign rdata = {1'b0, cfg_q};
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int PSC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [PSC_W-1:0] div_m1,
  output logic             tick
);
  logic [PSC_W-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == div_m1);

  always_comb begin
    if (!en || restart || tick) cnt_d = '0;
    else                        cnt_d = cnt_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rx,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= rx;
  end

  assign fall = prev_q && !rx;
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic             tq_tick,
  input  logic             rx_fall,
  input  logic             rx,
  input  logic [TS1_W-1:0] seg1_m1,
  input  logic [TS2_W-1:0] seg2_m1,
  input  logic [SJW_W-1:0] jump_m1,
  output logic             hard_sync,
  output logic             sample_stb,
  output logic             bit_start,
  output logic             rx_sampled
);
  localparam int WA  = (TS1_W > TS2_W) ? TS1_W : TS2_W;
  localparam int WM  = (WA > SJW_W) ? WA : SJW_W;
  localparam int Q_W = WM + 1;

  seg_t           seg_q, seg_d;
  logic [Q_W-1:0] qcnt_q, qcnt_d;
  logic [Q_W-1:0] adj_q, adj_d;
  logic           done_q, done_d;
  logic           smp_q, smp_d;
  logic           bst_q, bst_d;
  logic           rxs_q, rxs_d;

  logic [Q_W-1:0] s1_x, s2_x, jw_x;
  logic [Q_W-1:0] err1, err2, lim1, lim2, adj_eff;
  logic           resync_ok, s1_end, s2_end;

  assign s1_x = Q_W'(seg1_m1);
  assign s2_x = Q_W'(seg2_m1);
  assign jw_x = Q_W'(jump_m1) + Q_W'(1);

  // phase error: late edge in segment 1, early edge in segment 2
  assign err1 = qcnt_q + Q_W'(1);
  assign err2 = s2_x + Q_W'(1) - qcnt_q;
  assign lim1 = (err1 < jw_x) ? err1 : jw_x;
  assign lim2 = (err2 < jw_x) ? err2 : jw_x;

  assign resync_ok = !halt && rx_fall && !done_q;
  assign hard_sync = !halt && rx_fall && (seg_q == SEG_IDLE);

  always_comb begin
    adj_eff = adj_q;
    if (resync_ok && seg_q == SEG_TS1) adj_eff = lim1;
    if (resync_ok && seg_q == SEG_TS2) adj_eff = lim2;
  end

  assign s1_end = ({1'b0, qcnt_q} == ({1'b0, s1_x} + {1'b0, adj_eff}));
  assign s2_end = (({1'b0, qcnt_q} + {1'b0, adj_eff}) >= {1'b0, s2_x});

  always_comb begin
    seg_d  = seg_q;
    qcnt_d = qcnt_q;
    adj_d  = adj_q;
    done_d = done_q;
    smp_d  = 1'b0;
    bst_d  = 1'b0;
    rxs_d  = rxs_q;
    if (halt) begin
      seg_d  = SEG_IDLE;
      qcnt_d = '0;
      adj_d  = '0;
      done_d = 1'b0;
    end else begin
      case (seg_q)
        SEG_IDLE: begin
          if (hard_sync) begin
            seg_d  = SEG_SYNC;
            qcnt_d = '0;
            adj_d  = '0;
            done_d = 1'b0;
            bst_d  = 1'b1;
          end
        end
        SEG_SYNC: begin
          if (tq_tick) begin
            seg_d  = SEG_TS1;
            qcnt_d = '0;
          end
        end
        SEG_TS1: begin
          if (resync_ok) begin
            adj_d  = lim1;
            done_d = 1'b1;
          end
          if (tq_tick) begin
            if (s1_end) begin
              seg_d  = SEG_TS2;
              qcnt_d = '0;
              adj_d  = '0;
              smp_d  = 1'b1;
              rxs_d  = rx;
            end else begin
              qcnt_d = qcnt_q + Q_W'(1);
            end
          end
        end
        SEG_TS2: begin
          if (resync_ok) begin
            adj_d  = lim2;
            done_d = 1'b1;
          end
          if (tq_tick) begin
            if (s2_end) begin
              seg_d  = SEG_SYNC;
              qcnt_d = '0;
              adj_d  = '0;
              done_d = 1'b0;
              bst_d  = 1'b1;
            end else begin
              qcnt_d = qcnt_q + Q_W'(1);
            end
          end
        end
        default: seg_d = SEG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_IDLE;
      qcnt_q <= '0;
      adj_q  <= '0;
      done_q <= 1'b0;
      smp_q  <= 1'b0;
      bst_q  <= 1'b0;
      rxs_q  <= 1'b1;
    end else begin
      seg_q  <= seg_d;
      qcnt_q <= qcnt_d;
      adj_q  <= adj_d;
      done_q <= done_d;
      smp_q  <= smp_d;
      bst_q  <= bst_d;
      rxs_q  <= rxs_d;
    end
  end

  assign sample_stb = smp_q;
  assign bit_start  = bst_q;
  assign rx_sampled = rxs_q;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PSC_W = 6,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2,
  localparam int CFG_W = 1 + TS2_W + TS1_W + SJW_W + PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             rx,
  output logic             tq_tick,
  output logic             sample_stb,
  output logic             bit_start,
  output logic             rx_sampled
);
  localparam int PSC_LO = 0;
  localparam int SJW_LO = PSC_LO + PSC_W;
  localparam int TS1_LO = SJW_LO + SJW_W;
  localparam int TS2_LO = TS1_LO + TS1_W;

  logic [1:0] rst_pipe_q;
  logic       rst_s_n;
  logic       fall, hsync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  can_bt_cfgreg #(.CFG_W(CFG_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_s_n),
    .halt  (halt),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata)
  );

  can_bt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .en      (!halt),
    .restart (hsync),
    .div_m1  (cfg_rdata[PSC_LO +: PSC_W]),
    .tick    (tq_tick)
  );

  can_bt_edge u_edge (
    .clk   (clk),
    .rst_n (rst_s_n),
    .rx    (rx),
    .fall  (fall)
  );

  can_bt_seq #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .halt       (halt),
    .tq_tick    (tq_tick),
    .rx_fall    (fall),
    .rx         (rx),
    .seg1_m1    (cfg_rdata[TS1_LO +: TS1_W]),
    .seg2_m1    (cfg_rdata[TS2_LO +: TS2_W]),
    .jump_m1    (cfg_rdata[SJW_LO +: SJW_W]),
    .hard_sync  (hsync),
    .sample_stb (sample_stb),
    .bit_start  (bit_start),
    .rx_sampled (rx_sampled)
  );
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk #(
  parameter int CFG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             tq_tick,
  input logic             sample_stb,
  input logic             bit_start,
  input logic             rx_sampled
);
  assert_strobes_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_start));

  assert_cfg_frozen_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !halt |=> $stable(cfg_rdata));

  assert_top_bit_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[CFG_W-1]);

  assert_quiet_when_halted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!sample_stb && !bit_start && (!tq_tick || !halt)));

  assert_sample_follows_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> $past(tq_tick));

  assert_sampled_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |-> $stable(rx_sampled));
endmodule

bind can_bit_timer can_bit_timer_chk #(.CFG_W(CFG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .halt       (halt),
  .cfg_rdata  (cfg_rdata),
  .tq_tick    (tq_tick),
  .sample_stb (sample_stb),
  .bit_start  (bit_start),
  .rx_sampled (rx_sampled)
);

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n, halt, cfg_wr, rx;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        tq_tick, sample_stb, bit_start, rx_sampled;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  int   bs_e[4];
  int   smp_e[4];
  logic rxs_e[4];

  always #5 clk = ~clk;

  can_bit_timer u_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .halt(halt), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx(rx),
    .tq_tick(tq_tick), .sample_stb(sample_stb), .bit_start(bit_start),
    .rx_sampled(rx_sampled)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog R1..all: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // rx level driven as the input of cycle k after a hard sync
  function automatic logic rx_for(input int scn, input int k);
    case (scn)
      1:       return (k == 21) || (k == 26) || (k == 27);
      2:       return (k >= 21) && (k <= 25);
      3:       return (k >= 21) && (k <= 35);
      default: return 1'b0;
    endcase
  endfunction

  task automatic go_idle();
    @(negedge clk); halt = 1'b1; rx = 1'b1;
    repeat (2) @(negedge clk);
    halt = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // config word 0x2541: T2=2, T1=5, J=1, P=1 -> 2-clock quantum, 20-clock bit
  task automatic run_scn(input string tag, input int scn, input int len);
    go_idle();
    rx = 1'b0;
    for (int k = 0; k < len; k++) begin
      logic eb, es;
      int   si;
      @(negedge clk);
      eb = 1'b0; es = 1'b0; si = -1;
      for (int j = 0; j < 4; j++) begin
        if (bs_e[j] == k) eb = 1'b1;
        if (smp_e[j] == k) begin es = 1'b1; si = j; end
      end
      chk($sformatf("%s bit_start k=%0d", tag, k), {31'd0, bit_start}, {31'd0, eb});
      chk($sformatf("%s sample_stb k=%0d", tag, k), {31'd0, sample_stb}, {31'd0, es});
      chk($sformatf("R12 exclusive k=%0d", k), {31'd0, bit_start & sample_stb}, 32'd0);
      if (si >= 0)
        chk($sformatf("R10 rx_sampled k=%0d", k), {31'd0, rx_sampled}, {31'd0, rxs_e[si]});
      if (scn == 0)
        chk($sformatf("R4 tq_tick k=%0d", k), {31'd0, tq_tick}, 32'(k % 2));
      rx = rx_for(scn, k);
    end
  endtask

  task automatic t_reset();
    chk("R1 cfg_rdata", 32'(cfg_rdata), 32'h7FFF);
    chk("R1 bit_start", {31'd0, bit_start}, 32'd0);
    chk("R1 sample_stb", {31'd0, sample_stb}, 32'd0);
    chk("R1 tq_tick", {31'd0, tq_tick}, 32'd0);
    chk("R1 rx_sampled", {31'd0, rx_sampled}, 32'd1);
  endtask

  task automatic t_config();
    @(negedge clk); halt = 1'b1; cfg_wdata = 16'hA541; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
    chk("R2 write while halted", 32'(cfg_rdata), 32'h2541);
    chk("R3 bit15 reads 0", {31'd0, cfg_rdata[15]}, 32'd0);
    halt = 1'b0; cfg_wdata = 16'h7FFF; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
    @(negedge clk);
    chk("R2 write while running ignored", 32'(cfg_rdata), 32'h2541);
  endtask

  task automatic t_halt();
    @(negedge clk); halt = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk("R11 halted bit_start", {31'd0, bit_start}, 32'd0);
      chk("R11 halted sample_stb", {31'd0, sample_stb}, 32'd0);
      chk("R4 halted tq_tick", {31'd0, tq_tick}, 32'd0);
      rx = ~rx;
    end
    halt = 1'b0; rx = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R11 idle bit_start", {31'd0, bit_start}, 32'd0);
      chk("R11 idle sample_stb", {31'd0, sample_stb}, 32'd0);
    end
    rx = 1'b0;
    @(negedge clk);
    chk("R6 hard sync after idle", {31'd0, bit_start}, 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; halt = 1'b1; cfg_wr = 1'b0; cfg_wdata = 16'h0; rx = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_config();

    bs_e  = '{0, 20, 40, -1};
    smp_e = '{14, 34, -1, -1};
    rxs_e = '{1'b0, 1'b0, 1'b0, 1'b0};
    run_scn("R5/R6 nominal", 0, 42);

    bs_e  = '{0, 20, 42, -1};
    smp_e = '{14, 36, -1, -1};
    run_scn("R9 one resync per bit", 1, 44);

    bs_e  = '{0, 20, 44, -1};
    smp_e = '{14, 38, -1, -1};
    run_scn("R7 lengthen limited", 2, 46);

    bs_e  = '{0, 20, 38, -1};
    smp_e = '{14, 34, 52, -1};
    rxs_e = '{1'b0, 1'b1, 1'b0, 1'b0};
    run_scn("R8 shorten", 3, 54);

    t_halt();

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule